// File: doc/BRIEF.md
# Multi-Rail Power-Good Sequencer

This block is the digital core of a four-rail supply supervisor. Four comparator results come in, one per rail. Each is high while its rail sits above its trip point. The block drives three per-rail enable outputs and one common power-good output, all as plain active-high logic levels. Each rail input first passes through its own two-flop synchroniser.

Enable output x follows only rail x, for x = 1 to 3, and rises after a short qualification delay. The power-good output rises only after all four rails, including the fourth rail that has no enable of its own, have been good together for a much longer qualification delay. Any drop takes effect at once and clears the matching qualification counter. The outputs always reflect the current rail state, so the same behaviour holds before and after power-good first rises. Both delays are given in time units and converted to clock cycles from the clock frequency parameter.

Top module: `rail_supervisor`

## Requirements
- R1: While rst_ni is low, en_o and pwr_ok_o are low and every qualification counter is clear. After release, all qualification restarts from zero.
- R2: Each rail bit passes through two flops before any logic uses it. A rail pulse shorter than the enable delay never reaches an output.
- R3: If rail x (bit x-1 of rail_i, x = 1..3) is high at N+1 consecutive rising edges ending at edge k-1, then en_o[x-1] is high after edge k. N is the enable delay in cycles.
- R4: en_o[x-1] depends only on rail_i[x-1]. Rail 4 (bit 3) has no effect on any enable.
- R5: If a rail bit is low at edge k, its enable is low after edge k+1, with no added delay.
- R6: A rail that drops during its delay window restarts its count from zero. The power-good count restarts whenever any rail drops.
- R7: pwr_ok_o is high after edge k only if all four rail bits were high at M+1 consecutive edges ending at edge k-1. M is the power-good delay in cycles.
- R8: A drop of rail 4 alone lowers only pwr_ok_o. en_o keeps its value.
- R9: There is no latching. The outputs follow the same rules before and after pwr_ok_o first rises.
- R10: N = floor(CLK_HZ*T_OUT_US/10^6) and M = floor(CLK_HZ*T_PG_MS/10^3), each at least 1.
- R11: When M >= N, pwr_ok_o high implies all three en_o bits are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rail_i | input | NUM_RAILS | Asynchronous rail-good comparator results; bit 3 is rail 4 |
| en_o | output | NUM_RAILS-1 | Delayed per-rail enables for rails 1 to 3 |
| pwr_ok_o | output | 1 | Common power-good output |

## Verification
The assertions are checked on every cycle. They cover the synchroniser latency, counter saturation, counter clearing after a drop, enables and power-good rising only from a counter at its last step with the synchronised condition held, and power-good implying every enable. The following can only be shown by the bench's scenarios, against a run-length model: exact rise edges, the isolation of the enables from rail 4, glitch restarts, and behaviour across a mid-run reset and repeated power-good cycles.

// File: rtl/rail_sup_pkg.sv
`timescale 1ns/1ps
package rail_sup_pkg;
  // cycles = floor(hz * t / scale), never below one
  function automatic int unsigned to_cycles(input longint unsigned hz,
                                            input longint unsigned t,
                                            input longint unsigned scale);
    longint unsigned c;
    c = (hz * t) / scale;
    if (c == 0) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/rail_sync.sv
`timescale 1ns/1ps
module rail_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];

  // R2
  sync_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni, STAGES) |-> sync_o == $past(async_i, STAGES));
endmodule

// File: rtl/qual_delay.sv
`timescale 1ns/1ps
module qual_delay #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          full;

  assign full = (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!good_i) cnt_q <= '0;
    else if (!full)   cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = good_i & full;

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  // R6
  drop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(good_i) |-> cnt_q == '0);
  // R3
  rise_after_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(good_i) && $past(cnt_q) == LIM - 1'b1);
endmodule

// File: rtl/rail_supervisor.sv
`timescale 1ns/1ps
module rail_supervisor
  import rail_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned T_OUT_US  = 30,
  parameter int unsigned T_PG_MS   = 190,
  parameter int unsigned NUM_RAILS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RAILS-1:0] rail_i,
  output logic [NUM_RAILS-2:0] en_o,
  output logic                 pwr_ok_o
);
  localparam int unsigned EN_CYC = to_cycles(CLK_HZ, T_OUT_US, 1_000_000);
  localparam int unsigned PG_CYC = to_cycles(CLK_HZ, T_PG_MS, 1_000);
  localparam int unsigned NUM_EN = NUM_RAILS - 1;

  logic [NUM_RAILS-1:0] rail_s;
  logic                 all_good;

  rail_sync #(.WIDTH(NUM_RAILS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(rail_i),
    .sync_o (rail_s)
  );

  // the last rail has no enable; it only gates power-good
  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    qual_delay #(.LIMIT(EN_CYC)) u_en (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .good_i(rail_s[g]),
      .ok_o  (en_o[g])
    );

    // R4
    en_own_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_o[g]) |-> $past(rail_s[g]));
  end

  assign all_good = &rail_s;

  qual_delay #(.LIMIT(PG_CYC)) u_pg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .good_i(all_good),
    .ok_o  (pwr_ok_o)
  );

  // R7
  pg_needs_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_ok_o) |-> $past(&rail_s));

  if (PG_CYC >= EN_CYC) begin : g_pg_order
    // R11
    pg_implies_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_ok_o |-> &en_o);
  end
endmodule

// File: tb/rail_supervisor_bench.sv
`timescale 1ns/1ps
module rail_supervisor_bench;
  localparam int CLK_HZ   = 100_000;
  localparam int T_OUT_US = 100;
  localparam int T_PG_MS  = 1;
  // R10: cycle counts from the stated formula
  localparam int EN_N = (CLK_HZ * T_OUT_US) / 1_000_000 < 1 ? 1 : (CLK_HZ * T_OUT_US) / 1_000_000;
  localparam int PG_M = (CLK_HZ * T_PG_MS) / 1_000 < 1 ? 1 : (CLK_HZ * T_PG_MS) / 1_000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] rail = 4'b0;
  logic [2:0] en;
  logic       pg;

  int nchk = 0;
  int nfail = 0;
  string tag = "R1";

  int run [3];
  int run_all;
  logic [2:0] exp_en;
  logic       exp_pg;

  always #2.5 clk = ~clk;

  rail_supervisor #(.CLK_HZ(CLK_HZ), .T_OUT_US(T_OUT_US), .T_PG_MS(T_PG_MS), .NUM_RAILS(4))
  u_rail_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .rail_i(rail), .en_o(en), .pwr_ok_o(pg)
  );

  function automatic int bump(input int r, input logic v);
    if (!v) return 0;
    return (r > 1_000_000) ? r : r + 1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 3; i++) run[i] = 0;
    run_all = 0;
    exp_en = '0;
    exp_pg = 1'b0;
  endtask

  task automatic compare();
    for (int i = 0; i < 3; i++) begin
      nchk++;
      if (en[i] !== exp_en[i]) begin
        nfail++;
        $display("FAIL %s en[%0d] got %b exp %b t=%0t", tag, i, en[i], exp_en[i], $time);
      end
    end
    nchk++;
    if (pg !== exp_pg) begin
      nfail++;
      $display("FAIL %s pwr_ok got %b exp %b t=%0t", tag, pg, exp_pg, $time);
    end
    // R11
    if (pg === 1'b1) begin
      nchk++;
      if (en !== 3'b111) begin
        nfail++;
        $display("FAIL R11 en got %b exp 111 while pwr_ok high", en);
      end
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic tick(input logic [3:0] v);
    rail = v;
    @(posedge clk);
    if (!rst_ni) model_clear();
    else begin
      for (int i = 0; i < 3; i++) begin
        exp_en[i] = (run[i] >= EN_N + 1);
        run[i] = bump(run[i], rail[i]);
      end
      exp_pg = (run_all >= PG_M + 1);
      run_all = bump(run_all, &rail);
    end
    @(negedge clk);
    compare();
  endtask

  task automatic hold(input logic [3:0] v, input int n);
    for (int k = 0; k < n; k++) tick(v);
  endtask

  initial begin
    #(5.0 * 150_000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [3:0] r;
    model_clear();
    void'($urandom(32'h5eed_0a11));
    // R1: outputs low while reset held, even with rails high
    tag = "R1";
    hold(4'b1111, 5);
    @(negedge clk) rst_ni = 1'b1;
    model_clear();

    // R3 R10: rail 1 alone rises exactly N+2 edges after being driven
    tag = "R3";
    hold(4'b0001, EN_N + 6);
    tag = "R10";
    hold(4'b0011, EN_N + 3);

    // R4: toggling rail 4 leaves the enables untouched
    tag = "R4";
    for (int k = 0; k < 20; k++) tick({k[1], 3'b011});

    // R5: immediate drop
    tag = "R5";
    hold(4'b0010, 4);
    hold(4'b0000, 4);

    // R2: short pulses never reach an enable
    tag = "R2";
    for (int k = 0; k < 6; k++) begin
      tick(4'b0111);
      tick(4'b0000);
    end

    // R6: glitch just before expiry restarts the count
    tag = "R6";
    hold(4'b0100, EN_N - 1);
    tick(4'b0000);
    hold(4'b0100, EN_N + 4);

    // R7: all four good long enough gives power-good
    tag = "R7";
    hold(4'b1111, PG_M + 6);

    // R8: rail 4 drops alone, enables stay high
    tag = "R8";
    hold(4'b0111, 3);
    hold(4'b1111, PG_M - 5);
    tick(4'b0111);
    hold(4'b1111, PG_M + 4);

    // R9: repeated power-good cycles with per-rail drops
    tag = "R9";
    for (int x = 0; x < 3; x++) begin
      hold(4'b1111 & ~(4'b1 << x), 3);
      hold(4'b1111, PG_M + 4);
    end

    // R1: asynchronous reset mid-run clears everything
    tag = "R1";
    @(negedge clk) rst_ni = 1'b0;
    #1;
    nchk++;
    if (en !== 3'b000 || pg !== 1'b0) begin
      nfail++;
      $display("FAIL R1 got en=%b pg=%b exp en=000 pg=0", en, pg);
    end
    model_clear();
    hold(4'b1111, 3);
    @(negedge clk) rst_ni = 1'b1;
    model_clear();
    hold(4'b1111, EN_N + 4);

    // R11 plus random: slowly changing rails so both delays are reached
    tag = "R11";
    r = 4'b1111;
    for (int k = 0; k < 4000; k++) begin
      for (int b = 0; b < 4; b++)
        if ($urandom_range(79) == 0) r[b] = ~r[b];
      tick(r);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule